// File: doc/BRIEF.md
# Physical Register Rename Unit

This block translates the logical register names of an in-order instruction stream into physical register numbers so that later stages can run instructions out of order without false write-after-write or write-after-read conflicts. It keeps two mapping tables. The speculative table follows every renamed instruction. The committed table follows only retired instructions. A pool of unused physical register numbers supplies a fresh destination for each instruction.

Each accepted rename reads the two source mappings and the old mapping of the destination from the speculative table, and takes a new physical register from the head of the free pool. The four numbers come out one cycle later. At retirement the commit port writes the instruction's physical register into the committed table and returns the register it displaces to the pool. No register value moves. A recovery pulse discards all speculative state. The speculative table becomes a copy of the committed table. The pool is then rebuilt by a scan over every physical register number, and renaming stalls until the scan ends. Reset uses the same scan, so the pool starts out holding every register that the identity map does not use.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i in both tables, and `ren_stall` stays high for at most NUM_PHYS+4 cycles before it falls.
- R2: When the pool is built by reset or by recovery, it holds every physical register that the committed table does not name, in ascending order. Allocation takes them in that order, so after reset the first destination is NUM_LOG (32), then 33, and so on.
- R3: Each source output is the speculative mapping left by all older accepted renames. `out_prev_phys` is the destination's speculative mapping before this rename, and it never equals `out_dst_phys`.
- R4: A source that names the instruction's own destination register gets the old mapping, not the fresh one.
- R5: When the pool is empty (NUM_PHYS-NUM_LOG renames with no commit since reset), `ren_stall` is high. A rename request made while `ren_stall` is high is dropped: `out_valid` stays low and the pool and tables do not change.
- R6: A commit of (`cmt_dst`, `cmt_phys`) returns the register that the committed table held for `cmt_dst` to the tail of the pool. Released registers are handed out in the order they were released, after any registers that were already in the pool.
- R7: A commit changes only the committed table. The speculative mappings that later sources read are unchanged.
- R8: A `recover` pulse makes `ren_stall` high in the next cycle and copies the committed table into the speculative table. When the stall ends, the pool is rebuilt as R2 describes. `recover` and `cmt_valid` must not be high in the same cycle or while the scan runs.
- R9: An accepted rename (`ren_valid` high, `ren_stall` low, `recover` low) raises `out_valid` for exactly one cycle at the next clock edge. The four physical numbers arrive in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_src_a | input | $clog2(NUM_LOG) | First source logical register |
| ren_src_b | input | $clog2(NUM_LOG) | Second source logical register |
| ren_dst | input | $clog2(NUM_LOG) | Destination logical register |
| ren_stall | output | 1 | Pool empty or rebuild in progress; requests are dropped |
| out_valid | output | 1 | Registered rename result valid |
| out_src_a_phys | output | $clog2(NUM_PHYS) | Physical register for source A |
| out_src_b_phys | output | $clog2(NUM_PHYS) | Physical register for source B |
| out_dst_phys | output | $clog2(NUM_PHYS) | Newly allocated destination |
| out_prev_phys | output | $clog2(NUM_PHYS) | Prior speculative mapping of the destination |
| cmt_valid | input | 1 | Retire one instruction |
| cmt_dst | input | $clog2(NUM_LOG) | Logical destination of the retiring instruction |
| cmt_phys | input | $clog2(NUM_PHYS) | Physical register of the retiring instruction |
| recover | input | 1 | Discard speculative state |

## Verification
The bench builds the block with its default sizes: 32 logical and 64 physical registers. With these sizes the 32 spare registers run out after 32 renames, so a short test reaches the empty-pool stall and the release order after it. Recovery is tested after a mix of renames and commits. The ascending rebuild then gives predictable numbers for the first allocations, and the committed mappings show up in the source outputs.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef enum logic {
    RN_RUN,
    RN_REBUILD
  } rn_state_e;
endpackage

// File: rtl/rename_free_fifo.sv
module rename_free_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  // storage has no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign head = mem[rptr];
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NL = 32,
  parameter int NP = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  recover,
  input  logic                  ren_we,
  input  logic [$clog2(NL)-1:0] ren_idx,
  input  logic [$clog2(NP)-1:0] ren_phys,
  input  logic [$clog2(NL)-1:0] rd_a_idx,
  input  logic [$clog2(NL)-1:0] rd_b_idx,
  input  logic [$clog2(NL)-1:0] rd_d_idx,
  output logic [$clog2(NP)-1:0] rd_a,
  output logic [$clog2(NP)-1:0] rd_b,
  output logic [$clog2(NP)-1:0] rd_d,
  input  logic                  cm_we,
  input  logic [$clog2(NL)-1:0] cm_idx,
  input  logic [$clog2(NP)-1:0] cm_phys,
  output logic [$clog2(NP)-1:0] cm_old,
  output logic [NP-1:0]         cm_used
);
  localparam int PW = $clog2(NP);

  logic [PW-1:0] spec_map [NL];
  logic [PW-1:0] cmt_map  [NL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) spec_map[i] <= PW'(i);
    end else if (recover) begin
      for (int i = 0; i < NL; i++) spec_map[i] <= cmt_map[i];
    end else if (ren_we) begin
      spec_map[ren_idx] <= ren_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) cmt_map[i] <= PW'(i);
      for (int p = 0; p < NP; p++) cm_used[p] <= (p < NL);
    end else if (cm_we) begin
      cmt_map[cm_idx]          <= cm_phys;
      cm_used[cmt_map[cm_idx]] <= 1'b0;
      cm_used[cm_phys]         <= 1'b1;
    end
  end

  assign rd_a   = spec_map[rd_a_idx];
  assign rd_b   = spec_map[rd_b_idx];
  assign rd_d   = spec_map[rd_d_idx];
  assign cm_old = cmt_map[cm_idx];
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ren_valid,
  input  logic [$clog2(NUM_LOG)-1:0]  ren_src_a,
  input  logic [$clog2(NUM_LOG)-1:0]  ren_src_b,
  input  logic [$clog2(NUM_LOG)-1:0]  ren_dst,
  output logic                        ren_stall,
  output logic                        out_valid,
  output logic [$clog2(NUM_PHYS)-1:0] out_src_a_phys,
  output logic [$clog2(NUM_PHYS)-1:0] out_src_b_phys,
  output logic [$clog2(NUM_PHYS)-1:0] out_dst_phys,
  output logic [$clog2(NUM_PHYS)-1:0] out_prev_phys,
  input  logic                        cmt_valid,
  input  logic [$clog2(NUM_LOG)-1:0]  cmt_dst,
  input  logic [$clog2(NUM_PHYS)-1:0] cmt_phys,
  input  logic                        recover
);
  import rename_pkg::*;

  localparam int PW = $clog2(NUM_PHYS);
  localparam int CW = PW + 1;

  rn_state_e     state;
  logic [PW-1:0] scan_idx;
  logic          rebuilding;
  logic          ren_fire;
  logic [CW-1:0] free_count;
  logic [PW-1:0] pool_head;
  logic          pool_push;
  logic [PW-1:0] pool_push_data;
  logic [PW-1:0] map_a, map_b, map_d, cm_old;
  logic [NUM_PHYS-1:0] cm_used;

  assign rebuilding = (state == RN_REBUILD);
  assign ren_stall  = rebuilding || (free_count == '0);
  assign ren_fire   = ren_valid && !ren_stall && !recover;

  // the rebuild scan and commit releases share the single push port
  assign pool_push      = rebuilding ? !cm_used[scan_idx] : cmt_valid;
  assign pool_push_data = rebuilding ? scan_idx : cm_old;

  always_ff @(posedge clk) begin
    if (rst || recover) begin
      state    <= RN_REBUILD;
      scan_idx <= '0;
    end else if (rebuilding) begin
      scan_idx <= scan_idx + 1'b1;
      if (scan_idx == PW'(NUM_PHYS-1)) state <= RN_RUN;
    end
  end

  rename_free_fifo #(.DEPTH(NUM_PHYS), .DW(PW)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .clear     (recover),
    .push      (pool_push),
    .push_data (pool_push_data),
    .pop       (ren_fire),
    .head      (pool_head),
    .count     (free_count)
  );

  rename_map_table #(.NL(NUM_LOG), .NP(NUM_PHYS)) u_maps (
    .clk      (clk),
    .rst      (rst),
    .recover  (recover),
    .ren_we   (ren_fire),
    .ren_idx  (ren_dst),
    .ren_phys (pool_head),
    .rd_a_idx (ren_src_a),
    .rd_b_idx (ren_src_b),
    .rd_d_idx (ren_dst),
    .rd_a     (map_a),
    .rd_b     (map_b),
    .rd_d     (map_d),
    .cm_we    (cmt_valid && !rebuilding),
    .cm_idx   (cmt_dst),
    .cm_phys  (cmt_phys),
    .cm_old   (cm_old),
    .cm_used  (cm_used)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= ren_fire;
  end

  always_ff @(posedge clk) begin
    if (ren_fire) begin
      out_src_a_phys <= map_a;
      out_src_b_phys <= map_b;
      out_dst_phys   <= pool_head;
      out_prev_phys  <= map_d;
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ren_valid,
  input logic                        ren_stall,
  input logic                        recover,
  input logic                        cmt_valid,
  input logic                        out_valid,
  input logic [$clog2(NUM_PHYS)-1:0] out_dst_phys,
  input logic [$clog2(NUM_PHYS)-1:0] out_prev_phys,
  input logic [$clog2(NUM_PHYS):0]   free_count
);
  localparam int CW = $clog2(NUM_PHYS) + 1;

  assert_drop_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_stall) |=> !out_valid);

  assert_pool_bound_R5: assert property (@(posedge clk) disable iff (rst)
    free_count <= CW'(NUM_PHYS - NUM_LOG));

  assert_accept_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_stall && !recover) |=> out_valid);

  assert_fresh_dst_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dst_phys != out_prev_phys));

  assert_recover_stall_R8: assert property (@(posedge clk) disable iff (rst)
    recover |=> ren_stall);

  assert_no_commit_recover_R8: assert property (@(posedge clk) disable iff (rst)
    !(recover && cmt_valid));
endmodule

bind rename_unit rename_unit_chk #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ren_valid     (ren_valid),
  .ren_stall     (ren_stall),
  .recover       (recover),
  .cmt_valid     (cmt_valid),
  .out_valid     (out_valid),
  .out_dst_phys  (out_dst_phys),
  .out_prev_phys (out_prev_phys),
  .free_count    (free_count)
);

// File: tb/tb_rename_unit.sv
`timescale 1ns/1ps
module tb_rename_unit;
  localparam int NL = 32;
  localparam int NP = 64;
  localparam int LW = $clog2(NL);
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ren_valid = 1'b0;
  logic [LW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
  logic          ren_stall, out_valid;
  logic [PW-1:0] out_src_a_phys, out_src_b_phys, out_dst_phys, out_prev_phys;
  logic          cmt_valid = 1'b0;
  logic [LW-1:0] cmt_dst = '0;
  logic [PW-1:0] cmt_phys = '0;
  logic          recover = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rename_unit #(.NUM_LOG(NL), .NUM_PHYS(NP)) dut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
    .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_stall(ren_stall),
    .out_valid(out_valid), .out_src_a_phys(out_src_a_phys),
    .out_src_b_phys(out_src_b_phys), .out_dst_phys(out_dst_phys),
    .out_prev_phys(out_prev_phys), .cmt_valid(cmt_valid), .cmt_dst(cmt_dst),
    .cmt_phys(cmt_phys), .recover(recover)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    int waited;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    waited = 0;
    while (ren_stall && waited < NP + 10) begin
      @(negedge clk);
      waited++;
    end
    check("R1", "reset-to-ready wait within bound", int'(waited <= NP + 4), 1);
  endtask

  task automatic rename_op(input int a, input int b, input int d,
                           output int sa, output int sb, output int dp,
                           output int pp, output int v);
    @(negedge clk);
    ren_valid = 1'b1;
    ren_src_a = LW'(a);
    ren_src_b = LW'(b);
    ren_dst   = LW'(d);
    @(negedge clk);
    ren_valid = 1'b0;
    sa = out_src_a_phys; sb = out_src_b_phys;
    dp = out_dst_phys;   pp = out_prev_phys;
    v  = out_valid;
  endtask

  task automatic commit_op(input int d, input int p);
    @(negedge clk);
    cmt_valid = 1'b1;
    cmt_dst   = LW'(d);
    cmt_phys  = PW'(p);
    @(negedge clk);
    cmt_valid = 1'b0;
  endtask

  task automatic test_reset_state();
    int sa, sb, dp, pp, v;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    do_reset();
    check("R1", "stall released", int'(ren_stall), 0);
    rename_op(3, 7, 10, sa, sb, dp, pp, v);
    check("R9", "out_valid after accept", v, 1);
    check("R1", "identity src a", sa, 3);
    check("R1", "identity src b", sb, 7);
    check("R1", "identity prev", pp, 10);
    check("R2", "first alloc", dp, NL);
    @(negedge clk);
    check("R9", "out_valid one cycle", int'(out_valid), 0);
  endtask

  task automatic test_chain();
    int sa, sb, dp, pp, v;
    do_reset();
    rename_op(1, 2, 5, sa, sb, dp, pp, v);
    check("R2", "alloc 0", dp, NL);
    rename_op(5, 5, 5, sa, sb, dp, pp, v);
    check("R4", "own dst not visible a", sa, NL);
    check("R4", "own dst not visible b", sb, NL);
    check("R3", "prev is older mapping", pp, NL);
    check("R2", "alloc 1", dp, NL + 1);
    rename_op(5, 1, 6, sa, sb, dp, pp, v);
    check("R3", "src sees older rename", sa, NL + 1);
    check("R3", "unrenamed src", sb, 1);
    check("R3", "prev of r6", pp, 6);
  endtask

  task automatic test_exhaust_and_commit();
    int sa, sb, dp, pp, v;
    int bad = 0;
    do_reset();
    for (int i = 0; i < NP - NL; i++) begin
      rename_op(i, i, i, sa, sb, dp, pp, v);
      if (dp != NL + i || v != 1) bad++;
    end
    check("R2", "ascending allocation run", bad, 0);
    check("R5", "stall when pool empty", int'(ren_stall), 1);
    rename_op(4, 4, 4, sa, sb, dp, pp, v);
    check("R5", "request dropped while stalled", v, 0);
    commit_op(0, NL);
    check("R6", "stall clears after release", int'(ren_stall), 0);
    commit_op(1, NL + 1);
    commit_op(2, NL + 2);
    rename_op(0, 4, 5, sa, sb, dp, pp, v);
    check("R7", "commit leaves spec map r0", sa, NL);
    check("R5", "dropped rename left r4", sb, NL + 4);
    check("R6", "first released reg", dp, 0);
    check("R3", "prev of r5", pp, NL + 5);
    rename_op(2, 2, 7, sa, sb, dp, pp, v);
    check("R6", "second released reg", dp, 1);
    check("R7", "commit leaves spec map r2", sa, NL + 2);
    rename_op(2, 2, 8, sa, sb, dp, pp, v);
    check("R6", "third released reg", dp, 2);
    check("R5", "stall after pool drained", int'(ren_stall), 1);
  endtask

  task automatic test_recover();
    int sa, sb, dp, pp, v;
    do_reset();
    rename_op(0, 0, 1, sa, sb, dp, pp, v);
    rename_op(0, 0, 2, sa, sb, dp, pp, v);
    rename_op(0, 0, 1, sa, sb, dp, pp, v);
    check("R3", "third alloc", dp, NL + 2);
    commit_op(1, NL);
    @(negedge clk);
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    check("R8", "stall after recover", int'(ren_stall), 1);
    while (ren_stall) @(negedge clk);
    rename_op(1, 2, 3, sa, sb, dp, pp, v);
    check("R8", "r1 from committed map", sa, NL);
    check("R8", "r2 speculative mapping dropped", sb, 2);
    check("R8", "prev of r3", pp, 3);
    check("R8", "rebuilt pool lowest free", dp, 1);
    rename_op(1, 1, 4, sa, sb, dp, pp, v);
    check("R8", "rebuilt pool next free", dp, NL + 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset_state();
    test_chain();
    test_exhaust_and_commit();
    test_recover();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule